// File: doc/BRIEF.md
# Two-Sided Doorbell and Heartbeat Register Block

This block connects two host-side register ports, side A and side B, that run on one shared clock. It gives each side a way to raise an interrupt on the other. It holds one 16-bit request register for each direction (A toward B, B toward A) and one mask register for each direction. It drives one registered interrupt line per side. A side sets bits in its outbound request register to ring the peer. The peer clears them once it has serviced them. Both sides can read and write both masks.

One request bit is reserved for liveness beats. A single-cycle pulse on the beat input of the currently active host sets that bit in the active host's outbound direction. The standby host then sees a recurring interrupt as long as the active host is healthy. Software cannot set the reserved bit. A beat from the standby side is dropped.

Each side sees the same register layout, relative to itself. Address 0 is its outbound ring register. Address 1 is the acknowledge register for its inbound requests. Address 2 is a read-only view of its raw inbound requests. Address 3 is the mask on its own interrupt. Address 4 is the mask on the peer's interrupt.

Top module: `xdom_doorbell`

## Requirements
- R1: After synchronous reset, all request bits are 0, all mask bits are 1, both interrupt outputs are 0 and both read-data outputs are 0.
- R2: A write at address 0 sets each outbound request bit where the write data holds a 1, and leaves the other bits unchanged. The result reads back at address 0 on the ringing side and at address 2 on the peer side.
- R3: A write at address 1 clears each inbound request bit where the write data holds a 1, and leaves the other bits unchanged.
- R4: If a request bit is set and cleared in the same cycle, it ends up set.
- R5: Each side's interrupt output is a register loaded every cycle with the OR, over all bits, of (inbound request AND NOT inbound mask). It therefore rises one clock edge after the request register or mask register changes.
- R6: Address 3 reads and writes the mask on the accessing side's own interrupt. Address 4 reads and writes the mask on the peer's interrupt. A mask bit of 1 blocks the request bit. If both sides write the same mask in one cycle, the side whose interrupt the mask controls wins.
- R7: Address 2 returns the raw inbound requests, ignoring the mask. Writes to address 2 change nothing.
- R8: A beat pulse from the side named by active_sel (0 = A, 1 = B) sets request bit 15 in that side's outbound direction. A beat from the other side has no effect. Software writes at address 0 never set bit 15.
- R9: When rd_en is high, rd_data is loaded on the next clock edge with the register value from before any write in that same cycle. Addresses 1, 5, 6 and 7 read as 0. rd_data holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| active_sel | input | 1 | Active host: 0 = A, 1 = B |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_addr | input | 3 | Side A register address |
| a_wdata | input | 16 | Side A write data |
| a_beat | input | 1 | Side A liveness pulse |
| a_rd_data | output | 16 | Side A registered read data |
| a_irq | output | 1 | Interrupt toward side A |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | 3 | Side B register address |
| b_wdata | input | 16 | Side B write data |
| b_beat | input | 1 | Side B liveness pulse |
| b_rd_data | output | 16 | Side B registered read data |
| b_irq | output | 1 | Interrupt toward side B |

## Verification
The assertions check the following every cycle:
- set bits stick, including set-over-clear;
- acknowledged bits drop;
- a fully masked direction keeps its interrupt low;
- the controlled side wins a mask collision;
- the reserved bit rises only after an accepted beat;
- read data holds between reads;
- the reset state.

Some behaviours only the bench's scenarios can show:
- the exact one-edge interrupt delay after unmasking;
- a standby beat and a write to the status address leaving all state unchanged;
- interleaved, random two-sided traffic matching a cycle-accurate behavioural model.

// File: rtl/xdb_pkg.sv
package xdb_pkg;
  localparam int XDB_ADDR_W = 3;

  typedef enum logic [XDB_ADDR_W-1:0] {
    REG_RING     = 3'd0,
    REG_ACK      = 3'd1,
    REG_STAT     = 3'd2,
    REG_MASK_IN  = 3'd3,
    REG_MASK_OUT = 3'd4
  } xdb_reg_e;
endpackage

// File: rtl/xdb_dir_reg.sv
// One signalling direction: request bits, mask bits and the registered interrupt.
module xdb_dir_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  input  logic         mask_we_rx,
  input  logic [W-1:0] mask_wd_rx,
  input  logic         mask_we_tx,
  input  logic [W-1:0] mask_wd_tx,
  output logic [W-1:0] req_q,
  output logic [W-1:0] mask_q,
  output logic         irq_q
);
  logic [W-1:0] req_d;
  logic [W-1:0] pend;

  // set dominates clear so no ring is lost
  assign req_d = (req_q & ~clr_bits) | set_bits;
  assign pend  = req_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      if (mask_we_rx)      mask_q <= mask_wd_rx;
      else if (mask_we_tx) mask_q <= mask_wd_tx;
      irq_q <= |pend;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (req_q == '0 && mask_q == '1 && !irq_q)); // R1
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    (|set_bits) |=> ((req_q & $past(set_bits)) == $past(set_bits))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (|(clr_bits & ~set_bits)) |=> ((req_q & $past(clr_bits & ~set_bits)) == '0)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|(clr_bits & set_bits)) |=> ((req_q & $past(clr_bits & set_bits)) == $past(clr_bits & set_bits))); // R4
  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> !irq_q); // R5
  AST_RX_MASK_WINS: assert property (@(posedge clk) disable iff (rst)
    mask_we_rx |=> (mask_q == $past(mask_wd_rx))); // R6
endmodule

// File: rtl/xdb_side_port.sv
// Register decode and registered readback for one side.
module xdb_side_port
  import xdb_pkg::*;
#(
  parameter int W      = 16,
  parameter int HB_BIT = W - 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [XDB_ADDR_W-1:0] addr,
  input  logic [W-1:0]          wdata,
  input  logic                  beat,
  input  logic                  beat_ok,
  input  logic [W-1:0]          out_req,
  input  logic [W-1:0]          in_req,
  input  logic [W-1:0]          out_mask,
  input  logic [W-1:0]          in_mask,
  output logic [W-1:0]          out_set,
  output logic [W-1:0]          in_clr,
  output logic                  in_mask_we,
  output logic                  out_mask_we,
  output logic [W-1:0]          rd_data
);
  localparam logic [W-1:0] HB_ONE = {{(W-1){1'b0}}, 1'b1} << HB_BIT;

  always_comb begin
    out_set = '0;
    if (wr_en && addr == REG_RING) out_set = wdata & ~HB_ONE;
    if (beat && beat_ok)           out_set = out_set | HB_ONE;
    in_clr = (wr_en && addr == REG_ACK) ? wdata : '0;
  end

  assign in_mask_we  = wr_en && (addr == REG_MASK_IN);
  assign out_mask_we = wr_en && (addr == REG_MASK_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (addr)
        REG_RING:     rd_data <= out_req;
        REG_STAT:     rd_data <= in_req;
        REG_MASK_IN:  rd_data <= in_mask;
        REG_MASK_OUT: rd_data <= out_mask;
        default:      rd_data <= '0;
      endcase
    end
  end

  AST_RD_RESET: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (rd_data == '0)); // R1
  AST_STAT_RAW: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == REG_STAT) |=> (rd_data == $past(in_req))); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R9
endmodule

// File: rtl/xdom_doorbell.sv
module xdom_doorbell
  import xdb_pkg::*;
#(
  parameter int W      = 16,
  parameter int HB_BIT = 15
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  active_sel,
  input  logic                  a_wr_en,
  input  logic                  a_rd_en,
  input  logic [XDB_ADDR_W-1:0] a_addr,
  input  logic [W-1:0]          a_wdata,
  input  logic                  a_beat,
  output logic [W-1:0]          a_rd_data,
  output logic                  a_irq,
  input  logic                  b_wr_en,
  input  logic                  b_rd_en,
  input  logic [XDB_ADDR_W-1:0] b_addr,
  input  logic [W-1:0]          b_wdata,
  input  logic                  b_beat,
  output logic [W-1:0]          b_rd_data,
  output logic                  b_irq
);
  localparam int NSIDE = 2;

  // index 0 = side A / direction A->B, index 1 = side B / direction B->A
  logic [NSIDE-1:0]                 wr_v, rd_v, beat_v, mwe_in, mwe_out, irq_v;
  logic [NSIDE-1:0][XDB_ADDR_W-1:0] adr_v;
  logic [NSIDE-1:0][W-1:0]          wd_v, set_v, clr_v, req_v, msk_v, rdd_v;

  assign wr_v   = {b_wr_en, a_wr_en};
  assign rd_v   = {b_rd_en, a_rd_en};
  assign beat_v = {b_beat, a_beat};
  assign adr_v  = {b_addr, a_addr};
  assign wd_v   = {b_wdata, a_wdata};

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    xdb_side_port #(.W(W), .HB_BIT(HB_BIT)) u_port (
      .clk         (clk),
      .rst         (rst),
      .wr_en       (wr_v[s]),
      .rd_en       (rd_v[s]),
      .addr        (adr_v[s]),
      .wdata       (wd_v[s]),
      .beat        (beat_v[s]),
      .beat_ok     (active_sel == (s == 1)),
      .out_req     (req_v[s]),
      .in_req      (req_v[1-s]),
      .out_mask    (msk_v[s]),
      .in_mask     (msk_v[1-s]),
      .out_set     (set_v[s]),
      .in_clr      (clr_v[s]),
      .in_mask_we  (mwe_in[s]),
      .out_mask_we (mwe_out[s]),
      .rd_data     (rdd_v[s])
    );

    xdb_dir_reg #(.W(W)) u_dir (
      .clk        (clk),
      .rst        (rst),
      .set_bits   (set_v[s]),
      .clr_bits   (clr_v[1-s]),
      .mask_we_rx (mwe_in[1-s]),
      .mask_wd_rx (wd_v[1-s]),
      .mask_we_tx (mwe_out[s]),
      .mask_wd_tx (wd_v[s]),
      .req_q      (req_v[s]),
      .mask_q     (msk_v[s]),
      .irq_q      (irq_v[s])
    );
  end

  assign a_rd_data = rdd_v[0];
  assign b_rd_data = rdd_v[1];
  assign a_irq     = irq_v[1];
  assign b_irq     = irq_v[0];

  AST_HB_ONLY_A: assert property (@(posedge clk) disable iff (rst)
    $rose(req_v[0][HB_BIT]) |-> $past(a_beat && !active_sel)); // R8
  AST_HB_ONLY_B: assert property (@(posedge clk) disable iff (rst)
    $rose(req_v[1][HB_BIT]) |-> $past(b_beat && active_sel)); // R8
endmodule

// File: tb/xdom_doorbell_tb_top.sv
module xdom_doorbell_tb_top;
  localparam int W  = 16;
  localparam int HB = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic active_sel = 1'b0;
  logic a_wr_en = 0, a_rd_en = 0, a_beat = 0, b_wr_en = 0, b_rd_en = 0, b_beat = 0;
  logic [2:0] a_addr = '0, b_addr = '0;
  logic [W-1:0] a_wdata = '0, b_wdata = '0;
  logic [W-1:0] a_rd_data, b_rd_data;
  logic a_irq, b_irq;

  xdom_doorbell #(.W(W), .HB_BIT(HB)) dut_i (
    .clk(clk), .rst(rst), .active_sel(active_sel),
    .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_beat(a_beat), .a_rd_data(a_rd_data), .a_irq(a_irq),
    .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_beat(b_beat), .b_rd_data(b_rd_data), .b_irq(b_irq)
  );

  int n_chk = 0, n_bad = 0;
  bit cmp_on = 0;
  string cur = "R1";

  task automatic chk(input logic [W-1:0] got, input logic [W-1:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference: [0] = A->B direction / side A, [1] = B->A / side B
  logic [W-1:0] m_req[2], m_mask[2], m_rd[2];
  logic         m_irq[2];

  function automatic logic [W-1:0] m_read(input int s, input logic [2:0] ad);
    case (ad)
      3'd0: return m_req[s];
      3'd2: return m_req[1-s];
      3'd3: return m_mask[1-s];
      3'd4: return m_mask[s];
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic [W-1:0] st[2], cl[2], nm[2], nr[2];
    logic wr[2], rd[2], bt[2];
    logic [2:0] ad[2];
    logic [W-1:0] wd[2];
    wr[0] = a_wr_en; wr[1] = b_wr_en; rd[0] = a_rd_en; rd[1] = b_rd_en;
    bt[0] = a_beat;  bt[1] = b_beat;  ad[0] = a_addr;  ad[1] = b_addr;
    wd[0] = a_wdata; wd[1] = b_wdata;
    if (rst) begin
      for (int d = 0; d < 2; d++) begin
        m_req[d] = '0; m_mask[d] = '1; m_irq[d] = 0; m_rd[d] = '0;
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        st[d] = '0;
        if (wr[d] && ad[d] == 3'd0) st[d] = wd[d] & ~(16'h1 << HB);
        if (bt[d] && (active_sel == (d == 1))) st[d] = st[d] | (16'h1 << HB);
        cl[d] = (wr[1-d] && ad[1-d] == 3'd1) ? wd[1-d] : '0;
        nm[d] = m_mask[d];
        if (wr[1-d] && ad[1-d] == 3'd3) nm[d] = wd[1-d];
        else if (wr[d] && ad[d] == 3'd4) nm[d] = wd[d];
        nr[d] = (m_req[d] & ~cl[d]) | st[d];
      end
      for (int s = 0; s < 2; s++) begin
        m_irq[s] = |(m_req[1-s] & ~m_mask[1-s]);
        if (rd[s]) m_rd[s] = m_read(s, ad[s]);
      end
      for (int d = 0; d < 2; d++) begin
        m_req[d] = nr[d]; m_mask[d] = nm[d];
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk({15'd0, a_irq}, {15'd0, m_irq[0]}, {cur, " a_irq model"});
      chk({15'd0, b_irq}, {15'd0, m_irq[1]}, {cur, " b_irq model"});
      chk(a_rd_data, m_rd[0], {cur, " a_rd_data model"});
      chk(b_rd_data, m_rd[1], {cur, " b_rd_data model"});
    end
  end

  task automatic wr(input bit s, input logic [2:0] ad, input logic [W-1:0] d);
    @(negedge clk);
    if (!s) begin a_wr_en = 1; a_addr = ad; a_wdata = d; end
    else    begin b_wr_en = 1; b_addr = ad; b_wdata = d; end
    @(negedge clk);
    a_wr_en = 0; b_wr_en = 0;
  endtask

  task automatic rd(input bit s, input logic [2:0] ad, output logic [W-1:0] v);
    @(negedge clk);
    if (!s) begin a_rd_en = 1; a_addr = ad; end
    else    begin b_rd_en = 1; b_addr = ad; end
    @(negedge clk);
    v = s ? b_rd_data : a_rd_data;
    a_rd_en = 0; b_rd_en = 0;
  endtask

  task automatic beat(input bit s);
    @(negedge clk);
    if (!s) a_beat = 1; else b_beat = 1;
    @(negedge clk);
    a_beat = 0; b_beat = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired got=running exp=done");
    finish_run();
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    // R1 reset state through the ports
    chk({15'd0, a_irq}, 16'h0, "R1 a_irq after reset");
    chk({15'd0, b_irq}, 16'h0, "R1 b_irq after reset");
    rd(0, 3'd0, v); chk(v, 16'h0000, "R1 A ring after reset");
    rd(1, 3'd2, v); chk(v, 16'h0000, "R1 B status after reset");
    rd(0, 3'd3, v); chk(v, 16'hffff, "R1 A own mask after reset");
    rd(1, 3'd4, v); chk(v, 16'hffff, "R1 B peer mask after reset");

    cur = "R2";
    wr(0, 3'd0, 16'h0009);
    wr(0, 3'd0, 16'h0002);
    rd(1, 3'd2, v); chk(v, 16'h000b, "R2 B status after A rings");
    rd(0, 3'd0, v); chk(v, 16'h000b, "R2 A ring readback");
    chk({15'd0, b_irq}, 16'h0, "R5 b_irq low while masked");

    cur = "R5";
    wr(1, 3'd3, 16'hfff7);
    chk({15'd0, b_irq}, 16'h0, "R5 b_irq not yet after unmask edge");
    @(negedge clk);
    chk({15'd0, b_irq}, 16'h1, "R5 b_irq one edge after unmask");

    cur = "R3";
    wr(1, 3'd1, 16'h0008);
    rd(1, 3'd2, v); chk(v, 16'h0003, "R3 B status after ack");
    chk({15'd0, b_irq}, 16'h0, "R3 b_irq drops after ack");

    cur = "R4";
    wr(0, 3'd0, 16'h0010);
    @(negedge clk);
    a_wr_en = 1; a_addr = 3'd0; a_wdata = 16'h0010;
    b_wr_en = 1; b_addr = 3'd1; b_wdata = 16'h0013;
    @(negedge clk);
    a_wr_en = 0; b_wr_en = 0;
    rd(1, 3'd2, v); chk(v, 16'h0010, "R4 set wins over same-cycle clear");

    cur = "R6";
    wr(0, 3'd4, 16'hffef);
    rd(1, 3'd3, v); chk(v, 16'hffef, "R6 A writes peer mask, B sees own");
    chk({15'd0, b_irq}, 16'h1, "R6 unmasked bit 4 raises b_irq");
    @(negedge clk);
    a_wr_en = 1; a_addr = 3'd4; a_wdata = 16'h1234;
    b_wr_en = 1; b_addr = 3'd3; b_wdata = 16'h00ff;
    @(negedge clk);
    a_wr_en = 0; b_wr_en = 0;
    rd(0, 3'd4, v); chk(v, 16'h00ff, "R6 controlled side wins collision");

    cur = "R7";
    wr(1, 3'd2, 16'hffff);
    rd(1, 3'd2, v); chk(v, 16'h0010, "R7 status write ignored");
    rd(0, 3'd0, v); chk(v, 16'h0010, "R7 ring unchanged by status write");

    cur = "R8";
    active_sel = 0;
    beat(1);
    rd(0, 3'd2, v); chk(v, 16'h0000, "R8 standby beat ignored");
    beat(0);
    rd(1, 3'd2, v); chk(v, 16'h8010, "R8 active beat sets bit 15");
    wr(1, 3'd1, 16'h8000);
    wr(0, 3'd0, 16'h8000);
    rd(1, 3'd2, v); chk(v, 16'h0010, "R8 software cannot set bit 15");
    active_sel = 1;
    beat(1);
    rd(0, 3'd2, v); chk(v, 16'h8000, "R8 B beat when B active");

    cur = "R9";
    rd(0, 3'd1, v); chk(v, 16'h0000, "R9 ack address reads zero");
    rd(1, 3'd5, v); chk(v, 16'h0000, "R9 unmapped 5 reads zero");
    rd(0, 3'd7, v); chk(v, 16'h0000, "R9 unmapped 7 reads zero");
    repeat (3) @(negedge clk);

    cur = "R2/R3/R6 random";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      a_wr_en = ($urandom % 3) == 0; b_wr_en = ($urandom % 3) == 0;
      a_rd_en = ($urandom % 2) == 0; b_rd_en = ($urandom % 2) == 0;
      a_addr = 3'($urandom % 8);     b_addr = 3'($urandom % 8);
      a_wdata = 16'($urandom);       b_wdata = 16'($urandom);
      a_beat = ($urandom % 5) == 0;  b_beat = ($urandom % 5) == 0;
      if (($urandom % 50) == 0) active_sel = ~active_sel;
    end
    @(negedge clk);
    a_wr_en = 0; b_wr_en = 0; a_rd_en = 0; b_rd_en = 0; a_beat = 0; b_beat = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule